// File: doc/BRIEF.md
# Converter Start and Result Control Register

This block is the 8-bit control and status register that runs conversions for a 12-bit converter outside it. Software reaches it over a small register bus: address, write data, a byte write strobe, and a single-bit write path that sets or clears one bit by index. Reads are combinational. The register picks one of four start sources. It sends a one-cycle start pulse to the converter and holds a busy bit while the conversion runs.

When the converter reports that it is done, the block stores the 12-bit sample and sets a sticky completion flag. That flag is set on the same clock edge on which busy falls. A separate sticky flag records matches reported by an outside window comparator. The stored sample is shown on a 16-bit high/low byte pair, either right or left justified. The justification is applied when the pair is read, so changing the justify bit reformats a result that is already stored.

While the enable bit is low, the converter is held in shutdown and no start source has any effect. A start that arrives during a conversion is dropped and is not queued for later.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The register decodes at bus address 0xE8 and resets to 0x00. Its bits from MSB to LSB are: enable [7], burst [6], complete flag [5], busy [4], window flag [3], left-justify [2], start mode [1:0].
- R2: A byte write (`bus_we`) replaces the writable bits. A bit write (`bus_bit_we`) sets or clears only bit `bus_bit_idx` to `bus_bit_val`. Either kind of write to any other address has no effect.
- R3: In start mode 00, writing 1 to bit 4 (byte or bit write) starts a conversion. `conv_start` pulses for one cycle, and busy reads 1 from the edge that takes the write.
- R4: Writing 0 to bit 4 has no effect. Writing 1 to bit 4 while start mode is not 00 starts nothing.
- R5: Start mode 01 starts a conversion on a `tmr1_ovf` pulse. Start mode 11 starts one on a `tmr2_ovf` pulse.
- R6: Start mode 10 starts a conversion on a rising edge of `cnv_pin`, taken after a two-flop synchronizer. Holding the pin high does not start a second conversion.
- R7: Busy stays 1 from the start until the converter asserts `conv_done`, then reads 0. The sample on `conv_data` is stored at that edge.
- R8: The complete flag is set on the edge where busy falls. It stays set until software writes it to 0.
- R9: A `win_match` pulse sets the window flag. Writes to other bits leave it set. Only a software write of 0 clears it.
- R10: With left-justify 0, `{res_hi,res_lo}` = `{4'b0, sample}`. With left-justify 1, it equals `{sample, 4'b0}`. The justify bit is applied to the stored sample when it is read.
- R11: While enable is 0, `conv_shutdown` is 1 and no start source starts a conversion.
- R12: A start trigger of any kind that arrives while busy is 1 is ignored and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register bus address |
| bus_wdata | input | 8 | Byte write data |
| bus_we | input | 1 | Byte write strobe |
| bus_bit_we | input | 1 | Single-bit write strobe |
| bus_bit_idx | input | 3 | Bit index for a single-bit write |
| bus_bit_val | input | 1 | Value for a single-bit write |
| bus_rdata | output | 8 | Current register contents |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| cnv_pin | input | 1 | Asynchronous external convert-start pin |
| win_match | input | 1 | Window comparator match pulse |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_shutdown | output | 1 | Holds the converter in shutdown |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter sample, valid with conv_done |
| res_hi | output | 8 | High byte of the formatted result |
| res_lo | output | 8 | Low byte of the formatted result |

## Verification
The assertions check, on every cycle, the ordering relations between busy and the start pulse. A start never follows a busy cycle and never happens while the block is disabled. Every rise of busy comes with a start pulse, every fall of busy leaves the complete flag set, and the window flag survives any cycle without a software clear. Only the bench scenarios can show that each of the four start sources actually fires in its own mode and in no other. They also show that single-bit writes touch only their target bit and that the synchronized pin starts exactly once per rising edge. Finally, the scoreboard shows that the result bytes carry the right sample in the right justification.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_EN    = 7;
  localparam int BIT_BURST = 6;
  localparam int BIT_CMPL  = 5;
  localparam int BIT_BUSY  = 4;
  localparam int BIT_WIN   = 3;
  localparam int BIT_LJ    = 2;

  // bits that are plain storage (enable, burst, left-justify, mode)
  localparam logic [REG_W-1:0] PLAIN_MASK = 8'b1100_0111;

  typedef enum logic [1:0] {
    SRC_SOFT  = 2'b00,
    SRC_TMR1  = 2'b01,
    SRC_PIN   = 2'b10,
    SRC_TMR2  = 2'b11
  } start_src_e;

  // merge a write value into the current value under a mask
  function automatic logic [REG_W-1:0] merge_bits(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] val,
                                                  input logic [REG_W-1:0] msk);
    return (cur & ~msk) | (val & msk);
  endfunction
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  start_src_e mode,
  input  logic       sw_start,
  input  logic       tmr1_ovf,
  input  logic       tmr2_ovf,
  input  logic       pin_async,
  output logic       trig,
  output logic       pin_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= pin_async;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= 1'b0;
    else        pin_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign pin_rise = sync_q[SYNC_STAGES-1] & ~pin_prev_q;

  always_comb begin
    unique case (mode)
      SRC_SOFT: trig = sw_start;
      SRC_TMR1: trig = tmr1_ovf;
      SRC_PIN:  trig = pin_rise;
      SRC_TMR2: trig = tmr2_ovf;
      default:  trig = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int RES_W  = 12,
  parameter int WORD_W = 16
) (
  input  logic [RES_W-1:0]    raw,
  input  logic                left,
  output logic [WORD_W/2-1:0] hi,
  output logic [WORD_W/2-1:0] lo
);
  localparam int PAD = WORD_W - RES_W;
  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] word;

  always_comb begin
    if (left) word = {raw, {PAD{1'b0}}};
    else      word = {{PAD{1'b0}}, raw};
  end

  assign hi = word[WORD_W-1:HALF];
  assign lo = word[HALF-1:0];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_ctl_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter logic [7:0]      REG_ADDR    = 8'hE8,
  parameter int              RES_W       = 12,
  parameter int              WORD_W      = 16,
  parameter int              SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [REG_W-1:0]          bus_wdata,
  input  logic                      bus_we,
  input  logic                      bus_bit_we,
  input  logic [$clog2(REG_W)-1:0]  bus_bit_idx,
  input  logic                      bus_bit_val,
  output logic [REG_W-1:0]          bus_rdata,
  input  logic                      tmr1_ovf,
  input  logic                      tmr2_ovf,
  input  logic                      cnv_pin,
  input  logic                      win_match,
  output logic                      conv_start,
  output logic                      conv_shutdown,
  input  logic                      conv_done,
  input  logic [RES_W-1:0]          conv_data,
  output logic [WORD_W/2-1:0]       res_hi,
  output logic [WORD_W/2-1:0]       res_lo
);
  logic [REG_W-1:0] plain_q;
  logic             busy_q, cmpl_q, win_q, conv_start_q;
  logic [RES_W-1:0] raw_q;

  logic             addr_hit, full_wr, bit_wr, any_wr;
  logic [REG_W-1:0] cur_val, wr_val, wr_msk;
  logic             sw_busy_one, sw_clr_win, trig, pin_rise;
  logic             start_fire, done_evt;

  assign addr_hit = (bus_addr == REG_ADDR[ADDR_W-1:0]);
  assign full_wr  = bus_we & addr_hit;
  assign bit_wr   = bus_bit_we & addr_hit & ~bus_we;
  assign any_wr   = full_wr | bit_wr;

  always_comb begin
    cur_val = plain_q;
    cur_val[BIT_CMPL] = cmpl_q;
    cur_val[BIT_BUSY] = busy_q;
    cur_val[BIT_WIN]  = win_q;
  end

  always_comb begin
    wr_val = cur_val;
    wr_msk = '0;
    if (full_wr) begin
      wr_val = bus_wdata;
      wr_msk = '1;
    end else if (bit_wr) begin
      wr_val[bus_bit_idx] = bus_bit_val;
      wr_msk[bus_bit_idx] = 1'b1;
    end
  end

  assign sw_busy_one = any_wr & wr_msk[BIT_BUSY] & wr_val[BIT_BUSY];
  assign sw_clr_win  = any_wr & wr_msk[BIT_WIN] & ~wr_val[BIT_WIN];

  adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (start_src_e'(plain_q[1:0])),
    .sw_start  (sw_busy_one),
    .tmr1_ovf  (tmr1_ovf),
    .tmr2_ovf  (tmr2_ovf),
    .pin_async (cnv_pin),
    .trig      (trig),
    .pin_rise  (pin_rise)
  );

  assign start_fire = trig & plain_q[BIT_EN] & ~busy_q;
  assign done_evt   = busy_q & conv_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_q      <= '0;
      busy_q       <= 1'b0;
      cmpl_q       <= 1'b0;
      win_q        <= 1'b0;
      conv_start_q <= 1'b0;
      raw_q        <= '0;
    end else begin
      if (any_wr) plain_q <= merge_bits(plain_q, wr_val, wr_msk & PLAIN_MASK);
      conv_start_q <= start_fire;
      if (start_fire)    busy_q <= 1'b1;
      else if (done_evt) busy_q <= 1'b0;
      if (done_evt) begin
        cmpl_q <= 1'b1;
        raw_q  <= conv_data;
      end else if (any_wr && wr_msk[BIT_CMPL]) begin
        cmpl_q <= wr_val[BIT_CMPL];
      end
      if (win_match)                        win_q <= 1'b1;
      else if (any_wr && wr_msk[BIT_WIN])   win_q <= wr_val[BIT_WIN];
    end
  end

  adc_result_fmt #(.RES_W(RES_W), .WORD_W(WORD_W)) u_fmt (
    .raw  (raw_q),
    .left (plain_q[BIT_LJ]),
    .hi   (res_hi),
    .lo   (res_lo)
  );

  assign bus_rdata     = cur_val;
  assign conv_start    = conv_start_q;
  assign conv_shutdown = ~plain_q[BIT_EN];

  // R3: busy only rises together with a start pulse to the converter
  assert_rise_has_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> conv_start);
  // R8: the completion flag is up whenever busy has just fallen
  assert_cmpl_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> cmpl_q);
  // R9: the window flag persists unless software clears it
  assert_win_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q && !sw_clr_win) |=> win_q);
  // R11: no start pulse follows a disabled cycle
  assert_start_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(plain_q[BIT_EN]));
  // R12: no start pulse follows a busy cycle
  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(busy_q));
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int LAT = 5;
  localparam logic [7:0] A_REG = 8'hE8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_we = 0, bus_bit_we = 0, bus_bit_val = 0;
  logic [2:0]  bus_bit_idx = '0;
  logic [7:0]  bus_rdata;
  logic        tmr1_ovf = 0, tmr2_ovf = 0, cnv_pin = 0, win_match = 0;
  logic        conv_start, conv_shutdown;
  logic        conv_done = 0;
  logic [11:0] conv_data = '0;
  logic [7:0]  res_hi, res_lo;

  adc_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_bit_we(bus_bit_we), .bus_bit_idx(bus_bit_idx),
    .bus_bit_val(bus_bit_val), .bus_rdata(bus_rdata), .tmr1_ovf(tmr1_ovf),
    .tmr2_ovf(tmr2_ovf), .cnv_pin(cnv_pin), .win_match(win_match),
    .conv_start(conv_start), .conv_shutdown(conv_shutdown),
    .conv_done(conv_done), .conv_data(conv_data), .res_hi(res_hi), .res_lo(res_lo)
  );

  int n_chk = 0, n_err = 0, n_starts = 0, cyc = 0;

  function automatic logic [11:0] sample_of(int k);
    return 12'h5A3 ^ 12'(k * 311);
  endfunction

  // converter stub: answers a fixed number of cycles after each start
  int lat_cnt = 0;
  int stub_k = 0;
  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      lat_cnt  <= LAT;
      n_starts <= n_starts + 1;
    end else if (lat_cnt > 1) lat_cnt <= lat_cnt - 1;
    else if (lat_cnt == 1) begin
      lat_cnt   <= 0;
      conv_done <= 1'b1;
      conv_data <= sample_of(stub_k);
      stub_k    <= stub_k + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [15:0] exp_q[$];
  int exp_k = 0;
  task automatic expect_conv(input logic left);
    logic [11:0] s;
    s = sample_of(exp_k);
    exp_k++;
    exp_q.push_back(left ? {s, 4'b0} : {4'b0, s});
  endtask

  logic busy_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_d && !bus_rdata[4]) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected completion", 32'(bus_rdata), 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({res_hi, res_lo} == e, "R10 result word", {res_hi, res_lo}, e);
          chk(bus_rdata[5], "R8 complete flag on busy fall", bus_rdata[5], 1);
        end
      end
      busy_d = bus_rdata[4];
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic bwr(input logic [2:0] idx, input logic v);
    @(negedge clk); bus_addr = A_REG; bus_bit_idx = idx; bus_bit_val = v; bus_bit_we = 1;
    @(negedge clk); bus_bit_we = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 40 && bus_rdata[4]; i++) @(negedge clk);
    idle(1);
  endtask

  initial begin
    int s0;
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    chk(bus_rdata == 8'h00, "R1 reset value", bus_rdata, 8'h00);
    chk(conv_shutdown && !conv_start, "R11 reset shutdown", {conv_shutdown, conv_start}, 2'b10);

    // R1/R2 byte write layout, wrong address ignored
    wr(A_REG, 8'hC6);
    chk(bus_rdata == 8'hC6, "R1 byte write readback", bus_rdata, 8'hC6);
    wr(8'hE9, 8'h00);
    chk(bus_rdata == 8'hC6, "R2 other address ignored", bus_rdata, 8'hC6);
    bwr(3'd6, 1'b0);
    chk(bus_rdata == 8'h86, "R2 bit clear", bus_rdata, 8'h86);
    bwr(3'd0, 1'b1);
    chk(bus_rdata == 8'h87, "R2 bit set", bus_rdata, 8'h87);

    // R11 disabled: no start in mode 00
    wr(A_REG, 8'h00); s0 = n_starts;
    wr(A_REG, 8'h10); idle(3);
    chk(n_starts == s0 && !bus_rdata[4], "R11 disabled no start", n_starts - s0, 0);
    chk(conv_shutdown, "R11 shutdown while disabled", conv_shutdown, 1);

    // R3 software start, R7 busy, R8 flag
    wr(A_REG, 8'h80);
    chk(!conv_shutdown, "R11 shutdown released", conv_shutdown, 0);
    s0 = n_starts;
    chk(n_starts == s0 && !bus_rdata[4], "R4 write 0 to busy no effect", bus_rdata, 8'h80);
    expect_conv(1'b0);
    wr(A_REG, 8'h90);
    chk(bus_rdata[4] && conv_start, "R3 busy and start pulse", {bus_rdata[4], conv_start}, 2'b11);
    idle(1);
    chk(!conv_start, "R3 start is one cycle", conv_start, 0);
    chk(bus_rdata[4], "R7 busy during conversion", bus_rdata[4], 1);
    wait_idle();
    chk(n_starts == s0 + 1, "R3 one conversion", n_starts - s0, 1);
    idle(3);
    chk(bus_rdata[5], "R8 flag sticky", bus_rdata[5], 1);
    bwr(3'd5, 1'b0);
    chk(!bus_rdata[5], "R8 software clear", bus_rdata[5], 0);

    // R10 left justified, then reformat stored sample
    bwr(3'd2, 1'b1);
    expect_conv(1'b1);
    bwr(3'd4, 1'b1); wait_idle();
    bwr(3'd2, 1'b0);
    chk({res_hi, res_lo} == {4'b0, sample_of(1)}, "R10 reformat to right", {res_hi, res_lo}, {4'b0, sample_of(1)});

    // R4 write 1 to busy in mode 01 starts nothing
    wr(A_REG, 8'h81); s0 = n_starts;
    wr(A_REG, 8'h91); idle(3);
    chk(n_starts == s0 && !bus_rdata[4], "R4 busy write in mode 01", n_starts - s0, 0);

    // R5 timer 1, R12 extra triggers while busy
    expect_conv(1'b0);
    @(negedge clk); tmr1_ovf = 1; @(negedge clk); tmr1_ovf = 0;
    idle(1);
    @(negedge clk); tmr1_ovf = 1; @(negedge clk); tmr1_ovf = 0;
    @(negedge clk); bus_addr = A_REG; bus_wdata = 8'h81; @(negedge clk);
    wait_idle(); idle(4);
    chk(n_starts == s0 + 1, "R12 trigger while busy dropped", n_starts - s0, 1);
    chk(!bus_rdata[4], "R12 nothing queued", bus_rdata[4], 0);

    // R5 timer 2 pulse ignored in mode 01, then used in mode 11
    s0 = n_starts;
    @(negedge clk); tmr2_ovf = 1; @(negedge clk); tmr2_ovf = 0; idle(2);
    chk(n_starts == s0, "R5 timer2 ignored in mode 01", n_starts - s0, 0);
    wr(A_REG, 8'h83);
    expect_conv(1'b0);
    @(negedge clk); tmr2_ovf = 1; @(negedge clk); tmr2_ovf = 0;
    wait_idle();
    chk(n_starts == s0 + 1, "R5 timer2 start", n_starts - s0, 1);

    // R6 pin edge after synchronizer, level does not restart
    wr(A_REG, 8'h82); s0 = n_starts;
    expect_conv(1'b0);
    @(negedge clk); cnv_pin = 1;
    idle(1);
    chk(!bus_rdata[4], "R6 synchronizer delay", bus_rdata[4], 0);
    idle(2);
    chk(bus_rdata[4], "R6 pin start", bus_rdata[4], 1);
    wait_idle(); idle(10);
    chk(n_starts == s0 + 1, "R6 held level no restart", n_starts - s0, 1);
    cnv_pin = 0; idle(3);

    // R9 window flag
    @(negedge clk); win_match = 1; @(negedge clk); win_match = 0;
    chk(bus_rdata[3], "R9 window set", bus_rdata[3], 1);
    bwr(3'd2, 1'b1);
    chk(bus_rdata[3], "R9 survives other write", bus_rdata[3], 1);
    bwr(3'd3, 1'b0);
    chk(!bus_rdata[3], "R9 software clear", bus_rdata[3], 0);

    idle(3);
    chk(exp_q.size() == 0, "R7 all conversions completed", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule